// File: doc/BRIEF.md
# Page Table Walker for TLB Miss Resolution

This block resolves one TLB miss at a time in hardware. A miss arrives as a virtual page number on a valid/ready handshake. The walker forms the address of the page table entry from the current process's table base and the page number. It issues one read on a simple memory request port and waits as long as needed for the response. It then decodes the entry it reads back.

If the entry's valid bit is set, the walker presents a refill for the TLB. The refill carries the frame number, the dirty and referenced bits and the read/write/execute permissions. If the valid bit is clear, the walker raises a page-fault indication instead. In both cases the result stays on the outputs until the consumer acknowledges it. Only then does the walker take another miss.

The table base register is switched per process through a write port. The port only accepts writes flagged as privileged. Each walk uses the base value that was current when its miss was accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, mem_rsp_ready, refill_valid and fault_valid are all 0.
- R2: A miss is accepted in a cycle where miss_valid and miss_ready are both 1. miss_ready then stays 0 from the next cycle until the result has been acknowledged.
- R3: The read address is the table base plus the page number times 4, taken modulo 2^32 (one 32-bit entry per page). mem_req_valid and the address hold steady until mem_req_ready is seen.
- R4: After the read is accepted, the walker waits any number of cycles for mem_rsp_valid. mem_rsp_ready is 1 only while waiting, and a response pulse outside that wait is ignored.
- R5: An entry with bit 0 (valid) set gives refill_valid=1 and fault_valid=0. The refill carries refill_pfn = entry bits 31:12, refill_dirty = bit 1, refill_ref = bit 2, refill_perm = bits 5:3 (read in bit 3, write in bit 4, execute in bit 5), and refill_vpn = the missed page number.
- R6: An entry with bit 0 clear gives fault_valid=1, fault_vpn = the missed page number and refill_valid=0, whatever its other bits are.
- R7: The result and its fields stay stable while resp_ack is 0. The cycle after resp_ack is 1, both result valids are 0 and miss_ready is 1.
- R8: The base register takes ptbr_wdata only when ptbr_we and ptbr_priv are both 1. A write with ptbr_priv=0 leaves the base unchanged.
- R9: The base is sampled when a miss is accepted. A privileged base write during a walk changes only the address of later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A TLB miss is offered |
| miss_ready | output | 1 | Walker idle, can take a miss |
| miss_vpn | input | 20 | Virtual page number that missed |
| ptbr_we | input | 1 | Table base write strobe |
| ptbr_priv | input | 1 | Write is issued in privileged mode |
| ptbr_wdata | input | 32 | New table base |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 32 | Entry word |
| refill_valid | output | 1 | Valid translation for the TLB |
| refill_vpn | output | 20 | Page number of the refill |
| refill_pfn | output | 20 | Physical frame number |
| refill_dirty | output | 1 | Dirty bit of the entry |
| refill_ref | output | 1 | Referenced bit of the entry |
| refill_perm | output | 3 | Execute, write, read permissions |
| fault_valid | output | 1 | Page fault for the missed page |
| fault_vpn | output | 20 | Page number that faulted |
| resp_ack | input | 1 | Consumer takes the result |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, 4 KB pages and 32-bit entries. These widths make the 20-bit page number span the full range from 0 to 0xFFFFF. They also let a base near the top of the address space wrap the entry address. Request stalls and response latencies of zero to several cycles exercise both handshakes, including a stray response pulse while the request is still pending. Entries with the valid bit clear but the other bits set separate the fault path from the refill path.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } walk_state_e;

  // Entry status bit positions, decoded by the walker
  localparam int PTE_V_BIT    = 0;
  localparam int PTE_D_BIT    = 1;
  localparam int PTE_REF_BIT  = 2;
  localparam int PTE_PERM_LSB = 3;
  localparam int PERM_W       = 3;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_priv,
  input  logic [PA_W-1:0] wr_data,
  output logic [PA_W-1:0] base_q
);
  logic            load;
  logic [PA_W-1:0] base_d;

  always_comb begin
    load   = wr_en && wr_priv;
    base_d = load ? wr_data : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assert_ptbr_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv) |=> $stable(base_q));
  assert_ptbr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_priv) |=> (base_q == $past(wr_data)));
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic resp_ack,
  output logic miss_ready,
  output logic mem_req_valid,
  output logic mem_rsp_ready,
  output logic resp_valid,
  output logic accept,
  output logic capture
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_valid)    state_d = ST_READ;
      ST_READ: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP: if (resp_ack)      state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    miss_ready    = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_READ);
    mem_rsp_ready = (state_q == ST_WAIT);
    resp_valid    = (state_q == ST_RESP);
    accept        = miss_ready && miss_valid;
    capture       = mem_rsp_ready && mem_rsp_valid;
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !miss_ready);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
  assert_rsp_only_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_ready, mem_req_valid, mem_rsp_ready, resp_valid}));
  assert_idle_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ack) |=> (miss_ready && !resp_valid));
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PTE_W     = 32,
  parameter int PAGE_BITS = 12,
  localparam int PFN_W    = PTE_W - PAGE_BITS
) (
  input  logic [PTE_W-1:0] pte,
  output logic             valid,
  output logic [PFN_W-1:0] pfn,
  output logic             dirty,
  output logic             refd,
  output perm_t            perm
);
  localparam int RSV_LSB = PTE_PERM_LSB + PERM_W;

  logic unused_rsv_bits;

  always_comb begin
    valid = pte[PTE_V_BIT];
    dirty = pte[PTE_D_BIT];
    refd  = pte[PTE_REF_BIT];
    perm  = perm_t'(pte[PTE_PERM_LSB +: PERM_W]);
    pfn   = pte[PTE_W-1:PAGE_BITS];
    unused_rsv_bits = ^pte[PAGE_BITS-1:RSV_LSB];
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PTE_W     = 32,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PTE_W - PAGE_BITS,
  localparam int ENTRY_SH = $clog2(PTE_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic             ptbr_we,
  input  logic             ptbr_priv,
  input  logic [PA_W-1:0]  ptbr_wdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             refill_valid,
  output logic [VPN_W-1:0] refill_vpn,
  output logic [PFN_W-1:0] refill_pfn,
  output logic             refill_dirty,
  output logic             refill_ref,
  output logic [2:0]       refill_perm,
  output logic             fault_valid,
  output logic [VPN_W-1:0] fault_vpn,
  input  logic             resp_ack
);
  logic [PA_W-1:0]  base_q;
  logic             resp_valid, accept, capture;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [PTE_W-1:0] pte_q, pte_d;
  logic             pte_v;
  logic [PFN_W-1:0] pte_pfn;
  logic             pte_dirty, pte_ref;
  perm_t            pte_perm;

  ptw_base_reg #(.PA_W(PA_W)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(ptbr_we), .wr_priv(ptbr_priv),
    .wr_data(ptbr_wdata), .base_q(base_q)
  );

  ptw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .resp_ack(resp_ack), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_rsp_ready(mem_rsp_ready),
    .resp_valid(resp_valid), .accept(accept), .capture(capture)
  );

  // Request state: page number and entry address, enabled on acceptance
  always_comb begin
    vpn_d  = accept ? miss_vpn : vpn_q;
    addr_d = accept ? (base_q + (PA_W'(miss_vpn) << ENTRY_SH)) : addr_q;
    pte_d  = capture ? mem_rsp_data : pte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      addr_q <= '0;
      pte_q  <= '0;
    end else begin
      vpn_q  <= vpn_d;
      addr_q <= addr_d;
      pte_q  <= pte_d;
    end
  end

  ptw_pte_decode #(.PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS)) u_dec (
    .pte(pte_q), .valid(pte_v), .pfn(pte_pfn), .dirty(pte_dirty),
    .refd(pte_ref), .perm(pte_perm)
  );

  always_comb begin
    mem_req_addr = addr_q;
    refill_valid = resp_valid && pte_v;
    fault_valid  = resp_valid && !pte_v;
    refill_vpn   = vpn_q;
    fault_vpn    = vpn_q;
    refill_pfn   = pte_pfn;
    refill_dirty = pte_dirty;
    refill_ref   = pte_ref;
    refill_perm  = pte_perm;
  end

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(refill_valid && fault_valid));
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((refill_valid || fault_valid) && !resp_ack) |=>
      ($stable(refill_valid) && $stable(fault_valid) && $stable(refill_pfn)
       && $stable(refill_vpn) && $stable(refill_perm)));
  assert_no_result_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid || fault_valid) |-> !miss_ready);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk, rst_n;
  logic        miss_valid, miss_ready;
  logic [19:0] miss_vpn;
  logic        ptbr_we, ptbr_priv;
  logic [31:0] ptbr_wdata;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        refill_valid, refill_dirty, refill_ref, fault_valid;
  logic [19:0] refill_vpn, refill_pfn, fault_vpn;
  logic [2:0]  refill_perm;
  logic        resp_ack;
  int          total = 0, bad = 0;
  logic [31:0] cur_base;

  pt_walker u_pt_walker (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {vpn[19:0], entry[31:0]}
  localparam logic [51:0] VEC [6] = '{
    {20'h00000, 32'h1234503F},
    {20'hFFFFF, 32'hABCDE009},
    {20'h00123, 32'h00000000},
    {20'h80001, 32'hFFFFF036},
    {20'h00ABC, 32'h00001011},
    {20'h7FFFF, 32'hFFFFF025}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic base_write(input logic [31:0] d, input bit priv);
    @(negedge clk);
    ptbr_we = 1'b1; ptbr_priv = priv; ptbr_wdata = d;
    @(negedge clk);
    ptbr_we = 1'b0; ptbr_priv = 1'b0;
  endtask

  task automatic walk(input logic [19:0] vpn, input logic [31:0] pte,
                      input int stall, input int lat, input bit stray,
                      input logic [31:0] mid_base);
    logic [31:0] exp_addr;
    exp_addr = cur_base + {10'd0, vpn, 2'b00};
    @(negedge clk);
    chk(miss_ready, "R2 idle ready", {63'd0, miss_ready}, 1);
    miss_valid = 1'b1; miss_vpn = vpn;
    @(negedge clk);
    miss_valid = 1'b0; miss_vpn = ~vpn;
    chk(!miss_ready, "R2 busy", {63'd0, miss_ready}, 0);
    for (int s = 0; s < stall; s++) begin
      chk(mem_req_valid && mem_req_addr == exp_addr, "R3 addr held",
          {32'd0, mem_req_addr}, {32'd0, exp_addr});
      chk(!mem_rsp_ready, "R4 no rsp ready in request", {63'd0, mem_rsp_ready}, 0);
      if (stray) begin mem_rsp_valid = 1'b1; mem_rsp_data = ~pte; end
      if (s == 0 && mid_base != cur_base) begin
        ptbr_we = 1'b1; ptbr_priv = 1'b1; ptbr_wdata = mid_base;
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0; ptbr_we = 1'b0; ptbr_priv = 1'b0;
    end
    chk(mem_req_valid && mem_req_addr == exp_addr, "R3 addr R9 base sample",
        {32'd0, mem_req_addr}, {32'd0, exp_addr});
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(!mem_req_valid && mem_rsp_ready, "R4 waiting",
        {62'd0, mem_req_valid, mem_rsp_ready}, 1);
    for (int l = 0; l < lat; l++) begin
      @(negedge clk);
      chk(!refill_valid && !fault_valid && mem_rsp_ready && !miss_ready,
          "R4 latency wait", {62'd0, refill_valid, fault_valid}, 0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    for (int h = 0; h < 2; h++) begin
      if (pte[0]) begin
        chk(refill_valid && !fault_valid, "R5 refill flag",
            {62'd0, refill_valid, fault_valid}, 2);
        chk({refill_vpn, refill_pfn, refill_dirty, refill_ref, refill_perm}
            == {vpn, pte[31:12], pte[1], pte[2], pte[5:3]}, "R5 refill fields",
            {19'd0, refill_vpn, refill_pfn, refill_dirty, refill_ref, refill_perm},
            {19'd0, vpn, pte[31:12], pte[1], pte[2], pte[5:3]});
      end else begin
        chk(fault_valid && !refill_valid && fault_vpn == vpn, "R6 fault",
            {42'd0, fault_valid, refill_valid, fault_vpn},
            {42'd0, 2'b10, vpn});
      end
      if (h == 0) @(negedge clk);  // R7: held while no ack
    end
    resp_ack = 1'b1;
    @(negedge clk);
    resp_ack = 1'b0;
    chk(miss_ready && !refill_valid && !fault_valid, "R7 back to idle",
        {61'd0, miss_ready, refill_valid, fault_valid}, 4);
    cur_base = mid_base;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_valid = 0; miss_vpn = '0; ptbr_we = 0; ptbr_priv = 0;
    ptbr_wdata = '0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    resp_ack = 0; cur_base = '0;
    repeat (3) @(negedge clk);
    chk(miss_ready && !mem_req_valid && !mem_rsp_ready && !refill_valid && !fault_valid,
        "R1 reset", {59'd0, miss_ready, mem_req_valid, mem_rsp_ready, refill_valid,
        fault_valid}, 5'b10000);
    rst_n = 1'b1;

    base_write(32'h0010_0000, 1'b1);
    cur_base = 32'h0010_0000;
    foreach (VEC[i])
      walk(VEC[i][51:32], VEC[i][31:0], i % 3, i % 4, 1'b0, cur_base);

    // R8: unprivileged write ignored, seen through the next address
    base_write(32'h0F00_0000, 1'b0);
    walk(20'h00010, 32'h00042007, 1, 0, 1'b0, cur_base);

    // R4: stray response pulses while request pending are ignored
    walk(20'h00020, 32'h55555019, 3, 2, 1'b1, cur_base);

    // R9: privileged base switch during a walk applies to the next one
    walk(20'h00030, 32'h0000000D, 2, 1, 1'b0, 32'h0020_0000);
    walk(20'h00030, 32'h0000000C, 0, 0, 1'b0, cur_base);

    // R3: address wraps modulo 2^32
    base_write(32'hFFFF_F000, 1'b1);
    cur_base = 32'hFFFF_F000;
    walk(20'h00400, 32'hFEDCB027, 0, 3, 1'b0, cur_base);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule